// File: doc/BRIEF.md
# Serial Nonvolatile-RAM Command Port

This block is the device side of a three-wire serial port for a small RAM that has a nonvolatile shadow array. A fast system clock samples the chip-select, serial-clock and serial-data pins. The block waits for a framing `1`, collects an 8-bit command and acts on it. It either takes a 16-bit word into a 16-entry RAM or streams a RAM word back out on a data pin that is driven only while reading.

Five control commands do not move data. Each of them becomes a one-cycle strobe to a separate protection controller, which holds the write-enable and store state. That controller returns a write-enable level, which gates RAM writes, and a busy level, which blocks strobes and writes while a store is in progress.

Top module: `nvram_serial_port`

## Requirements
- R1: While chip select is high and no command has begun, zeros sampled on rising serial-clock edges are ignored. The first `1` sampled is taken as command bit 7, and the command is shifted in MSB first, one bit per rising serial-clock edge.
- R2: When the 8th command bit arrives, the low three bits select the action. 000 pulses `cmd_wrds_o`, 001 pulses `cmd_sto_o`, 010 pulses `cmd_enas_o`, 100 pulses `cmd_wren_o` and 101 pulses `cmd_rcl_o`. Each pulse is exactly one system cycle, at most one strobe is active at a time, and bits 6..3 have no effect on these five actions.
- R3: No strobe is issued if `busy_i` is high when the 8th command bit is taken.
- R4: Code 011 is a write to the address in command bits 6..3 (bit 6 is the address MSB). The data bits that follow arrive LSB first. The word is committed with a single `ram_we_o` pulse after chip select falls, and only when `wr_en_i` is high and `busy_i` is low in that cycle.
- R5: If chip select falls after k data bits, with 0 < k < 16, positions 0..k-1 take the new bits and all other positions keep the word's previous RAM contents. If no data bit has arrived, no write pulse is issued.
- R6: Data bits beyond the 16th wrap around, so data bit n replaces position n mod 16.
- R7: Codes 110 and 111 read the addressed word. Command bit 0 is ignored. `sdo_oe_o` rises and `sdo_o` shows bit 0 after the falling serial-clock edge of the 8th clock, and each later rising edge presents the next bit. Bit 15 is followed by bit 0 again.
- R8: `sdo_oe_o` is low, and `sdo_o` is held at 0, except during the data phase of a read. Both return low once chip select is low.
- R9: Chip select low discards a partly received command, so bits from before the drop never combine with bits sent after it.
- R10: The serial clock may stop for any length of time in mid-transfer, and shifting then resumes from the same bit.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Serial chip select, active high |
| sck_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, valid when `sdo_oe_o` is high |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |
| ram_addr_o | output | 4 | RAM word address |
| ram_wdata_o | output | DW | RAM write word |
| ram_we_o | output | 1 | RAM write pulse |
| ram_rdata_i | input | DW | RAM read word (combinational read) |
| wr_en_i | input | 1 | Write permission from the protection controller |
| busy_i | input | 1 | Store in progress |
| cmd_wren_o | output | 1 | Set-write-enable strobe |
| cmd_wrds_o | output | 1 | Clear-write-enable strobe |
| cmd_sto_o | output | 1 | Store strobe |
| cmd_rcl_o | output | 1 | Recall strobe |
| cmd_enas_o | output | 1 | Arm-automatic-store strobe |

## Verification
The hardest condition to reach is a write that chip select cuts short, or one that runs on past its 24th clock. There, the committed word mixes new bits with old ones, or newer bits replace earlier ones, and the result can only be seen by reading the word back. The stimulus reaches this by choosing random data-bit counts from 1 to 32 and dropping chip select right after the last bit. It also adds directed runs of 5 and 21 bits and a write whose clock stops for hundreds of cycles in mid-word. Every one of these is followed by a read, and a 17-bit read also exposes the wrap on the output.

// File: rtl/nvram_serial_port.sv
module nvram_serial_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [3:0]    ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_we_o,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic          wr_en_i,
  input  logic          busy_i,
  output logic          cmd_wren_o,
  output logic          cmd_wrds_o,
  output logic          cmd_sto_o,
  output logic          cmd_rcl_o,
  output logic          cmd_enas_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_INSTR, S_WDATA, S_RWAIT, S_RDATA, S_HOLD} st_t;

  st_t            st;
  logic [1:0]     cs_y, sdi_y;
  logic [2:0]     sck_y;
  logic [6:0]     ir;
  logic [2:0]     icnt;
  logic [DW-1:0]  wsh, rsh;
  logic [BW-1:0]  widx;
  logic           got, ld, oe;
  logic [4:0]     cmd;

  wire cs_s  = cs_y[1];
  wire sdi_s = sdi_y[1];
  wire sck_r = sck_y[1] & ~sck_y[2];
  wire sck_f = ~sck_y[1] & sck_y[2];
  wire [7:0] inst = {ir, sdi_s};

  assign sdo_o      = oe & rsh[0];
  assign sdo_oe_o   = oe;
  assign cmd_wren_o = cmd[0];
  assign cmd_wrds_o = cmd[1];
  assign cmd_sto_o  = cmd[2];
  assign cmd_rcl_o  = cmd[3];
  assign cmd_enas_o = cmd[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_y        <= '0;
      sdi_y       <= '0;
      sck_y       <= '0;
      st          <= S_IDLE;
      ir          <= '0;
      icnt        <= '0;
      wsh         <= '0;
      rsh         <= '0;
      widx        <= '0;
      got         <= 1'b0;
      ld          <= 1'b0;
      oe          <= 1'b0;
      cmd         <= '0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
      ram_we_o    <= 1'b0;
    end else begin
      cs_y     <= {cs_y[0], cs_i};
      sdi_y    <= {sdi_y[0], sdi_i};
      sck_y    <= {sck_y[1:0], sck_i};
      cmd      <= '0;
      ram_we_o <= 1'b0;
      if (!cs_s) begin
        if (st == S_WDATA && got) begin
          ram_we_o    <= wr_en_i & ~busy_i;
          ram_wdata_o <= wsh;
        end
        st  <= S_IDLE;
        oe  <= 1'b0;
        got <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (sck_r && sdi_s) begin
            ir   <= 7'd1;
            icnt <= 3'd1;
            st   <= S_INSTR;
          end
          S_INSTR: if (sck_r) begin
            ir   <= inst[6:0];
            icnt <= icnt + 3'd1;
            if (icnt == 3'd7) begin
              ram_addr_o <= inst[6:3];
              st         <= S_HOLD;
              casez (inst[2:0])
                3'b000: cmd[1] <= ~busy_i;
                3'b001: cmd[2] <= ~busy_i;
                3'b010: cmd[4] <= ~busy_i;
                3'b100: cmd[0] <= ~busy_i;
                3'b101: cmd[3] <= ~busy_i;
                3'b011: begin
                  st   <= S_WDATA;
                  ld   <= 1'b0;
                  widx <= '0;
                end
                default: st <= S_RWAIT;
              endcase
            end
          end
          S_WDATA: begin
            if (!ld) begin
              wsh <= ram_rdata_i;
              ld  <= 1'b1;
            end else if (sck_r) begin
              wsh[widx] <= sdi_s;
              widx      <= (widx == LAST) ? '0 : widx + 1'b1;
              got       <= 1'b1;
            end
          end
          S_RWAIT: if (sck_f) begin
            rsh <= ram_rdata_i;
            oe  <= 1'b1;
            st  <= S_RDATA;
          end
          S_RDATA: if (sck_r) rsh <= {rsh[0], rsh[DW-1:1]};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nvram_serial_port_sva.sv
module nvram_serial_port_sva (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sdo_oe_o,
  input logic ram_we_o,
  input logic wr_en_i,
  input logic busy_i,
  input logic [4:0] cmds
);
  p_oe_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdo_oe_o);
  p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmds));
  p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmds) |=> !(|cmds));
  p_cmd_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmds) |-> !$past(busy_i));
  p_we_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> ($past(wr_en_i) && !$past(busy_i)));
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |=> !ram_we_o);
  p_we_after_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> !$past(cs_s));
endmodule

bind nvram_serial_port nvram_serial_port_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdo_oe_o(sdo_oe_o),
  .ram_we_o(ram_we_o), .wr_en_i(wr_en_i), .busy_i(busy_i),
  .cmds({cmd_enas_o, cmd_rcl_o, cmd_sto_o, cmd_wrds_o, cmd_wren_o})
);

// File: tb/nvram_serial_port_tb.sv
module nvram_serial_port_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, wr_en = 1'b1, busy = 1'b0;
  logic sdo, sdo_oe, ram_we;
  logic [3:0] ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic c_wren, c_wrds, c_sto, c_rcl, c_enas;

  logic [15:0] mem [16];
  logic [15:0] exp_m [16];
  int cnt [5];
  int n_we = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  nvram_serial_port #(.DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_we_o(ram_we), .ram_rdata_i(ram_rdata),
    .wr_en_i(wr_en), .busy_i(busy),
    .cmd_wren_o(c_wren), .cmd_wrds_o(c_wrds), .cmd_sto_o(c_sto),
    .cmd_rcl_o(c_rcl), .cmd_enas_o(c_enas)
  );

  function automatic logic [15:0] init_word(int i);
    return 16'hA5C3 ^ (16'(i) * 16'h1111);
  endfunction

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] s, int n);
    logic [15:0] r = old;
    for (int i = 0; i < n; i++) r[i % 16] = s[i];
    return r;
  endfunction

  assign ram_rdata = mem[ram_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      for (int i = 0; i < 5; i++) cnt[i] <= 0;
      n_we <= 0;
    end else begin
      if (ram_we) begin
        mem[ram_addr] <= ram_wdata;
        n_we <= n_we + 1;
      end
      if (c_wren) cnt[0] <= cnt[0] + 1;
      if (c_wrds) cnt[1] <= cnt[1] + 1;
      if (c_sto)  cnt[2] <= cnt[2] + 1;
      if (c_rcl)  cnt[3] <= cnt[3] + 1;
      if (c_enas) cnt[4] <= cnt[4] + 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    sdi = b;
    wait_n(HALF);
    sck = 1'b1;
    wait_n(HALF);
    sck = 1'b0;
  endtask

  task automatic begin_cmd(int zeros);
    cs = 1'b1;
    wait_n(4);
    for (int i = 0; i < zeros; i++) bit_out(1'b0);
  endtask

  task automatic end_cmd();
    wait_n(HALF);
    cs = 1'b0;
    sdi = 1'b0;
    wait_n(12);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = 7; i > 7 - n; i--) bit_out(v[i]);
  endtask

  // strobe index: 0 wren(100) 1 wrds(000) 2 sto(001) 3 rcl(101) 4 enas(010)
  task automatic cmd_check(string req, int base [5], int idx);
    for (int k = 0; k < 5; k++)
      chk(req, 32'(cnt[k] - base[k]), (k == idx) ? 32'd1 : 32'd0);
  endtask

  task automatic cmd_op(logic [2:0] op, int zeros);
    logic [3:0] a = 4'($urandom);
    begin_cmd(zeros);
    send_bits({1'b1, a, op}, 8);
    end_cmd();
  endtask

  task automatic do_write(int a, logic [31:0] s, int nbits, int pause_at);
    int we0 = n_we;
    bit commit;
    begin_cmd(int'($urandom % 3));
    send_bits({1'b1, 4'(a), 3'b011}, 8);
    for (int i = 0; i < nbits; i++) begin
      if (i == pause_at) wait_n(300);
      bit_out(s[i]);
    end
    chk("R8 oe during write", 32'(sdo_oe), 32'd0);
    end_cmd();
    commit = wr_en && !busy && nbits > 0;
    if (commit) exp_m[a] = merge(exp_m[a], s, nbits);
    chk("R4/R5 write pulse count", 32'(n_we - we0), commit ? 32'd1 : 32'd0);
  endtask

  task automatic do_read(int a, int nbits, output logic [31:0] got);
    got = '0;
    begin_cmd(int'($urandom % 3));
    send_bits({1'b1, 4'(a), 2'b11, 1'b0}, 7);
    sdi = 1'($urandom);
    wait_n(HALF);
    sck = 1'b1;
    wait_n(HALF);
    chk("R7 oe before 8th falling edge", 32'(sdo_oe), 32'd0);
    sck = 1'b0;
    wait_n(HALF);
    chk("R7 oe after 8th falling edge", 32'(sdo_oe), 32'd1);
    got[0] = sdo;
    for (int i = 1; i < nbits; i++) begin
      sck = 1'b1;
      wait_n(HALF);
      got[i] = sdo;
      sck = 1'b0;
      wait_n(HALF);
    end
    end_cmd();
    chk("R8 oe low after chip select", {31'd0, sdo_oe}, 32'd0);
    chk("R8 sdo held low", {31'd0, sdo}, 32'd0);
  endtask

  task automatic read_check(string req, int a);
    logic [31:0] g;
    do_read(a, 16, g);
    chk(req, {16'd0, g[15:0]}, {16'd0, exp_m[a]});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int base [5];
    logic [31:0] g;
    void'($urandom(32'd20240611));
    wait_n(5);
    chk("R11 reset sdo/oe", {30'd0, sdo, sdo_oe}, 32'd0);
    chk("R11 reset strobes", {27'd0, c_wren, c_wrds, c_sto, c_rcl, c_enas}, 32'd0);
    chk("R11 reset ram port", {11'd0, ram_we, ram_addr, ram_wdata}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) exp_m[i] = init_word(i);
    wait_n(5);

    base = cnt; cmd_op(3'b100, 0); cmd_check("R2 wren", base, 0);
    base = cnt; cmd_op(3'b000, 0); cmd_check("R2 wrds", base, 1);
    base = cnt; cmd_op(3'b001, 0); cmd_check("R2 sto", base, 2);
    base = cnt; cmd_op(3'b101, 0); cmd_check("R2 rcl", base, 3);
    base = cnt; cmd_op(3'b010, 0); cmd_check("R2 enas", base, 4);

    base = cnt; cmd_op(3'b100, 6); cmd_check("R1 leading zeros", base, 0);

    busy = 1'b1;
    base = cnt; cmd_op(3'b101, 0); cmd_check("R3 busy blocks strobe", base, -1);
    busy = 1'b0;

    base = cnt;
    begin_cmd(0);
    send_bits(8'b1010_0000, 4);
    end_cmd();
    cmd_op(3'b000, 0);
    cmd_check("R9 abort then wrds", base, 1);

    for (int it = 0; it < 10; it++) begin
      int a = int'($urandom % 16);
      do_write(a, {16'd0, 16'($urandom)}, 16, -1);
    end
    for (int a = 0; a < 16; a++) read_check("R4/R7 readback", a);

    wr_en = 1'b0;
    do_write(2, 32'h0000_FFFF ^ {16'd0, exp_m[2]}, 16, -1);
    wr_en = 1'b1;
    read_check("R4 write without enable", 2);

    busy = 1'b1;
    do_write(4, 32'h0000_1234 ^ {16'd0, exp_m[4]}, 16, -1);
    busy = 1'b0;
    read_check("R4 write while busy", 4);

    do_write(3, 32'h0000_0015, 5, -1);
    read_check("R5 partial 5 bits", 3);
    do_write(6, 32'h0000_0000, 0, -1);
    read_check("R5 zero data bits", 6);

    do_write(7, 32'h001B_CDEF, 21, -1);
    read_check("R6 wrap 21 bits", 7);

    do_read(7, 17, g);
    chk("R7 wrap on output", {31'd0, g[16]}, {31'd0, exp_m[7][0]});

    do_write(9, 32'h0000_C3A9, 16, 9);
    read_check("R10 paused clock", 9);

    for (int it = 0; it < 25; it++) begin
      int sel = int'($urandom % 3);
      int a = int'($urandom % 16);
      if (sel == 0) do_write(a, $urandom, 1 + int'($urandom % 32), -1);
      else if (sel == 1) read_check("R4/R5/R6 random readback", a);
      else begin
        base = cnt; cmd_op(3'b010, int'($urandom % 4)); cmd_check("R1/R2 random enas", base, 4);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule